// File: doc/BRIEF.md
# Interrupt Enable and Poll Arbiter

This block sits between eight interrupt sources and a small CPU core: two external pins, four timers, an analog-to-digital converter and a serial port. Each source delivers a one-cycle request strobe, and the block keeps a sticky request flag for it. Two 4-bit enable registers, each read and written through a narrow register port, decide how every source is serviced.

A source whose enable bit is 1 is interrupt-driven. Its pending flag can raise the interrupt request output, which also carries the source index, and an acknowledge clears the flag of the source being presented. A source whose enable bit is 0 is polled. Its flag never reaches the interrupt output. Instead, software tests it with a poll-and-skip command, which reports whether to skip and clears the flag when it was set. A poll of an enabled source is invalid: it always reports no skip and leaves the flag alone. A source is therefore never serviced both ways.

When several interrupt-driven flags are pending, the lowest source index is presented first. A master enable input gates only the request output. Both enable registers return to zero on reset and on entry to the RAM back-up mode.

Top module: `irq_poll_arbiter`

## Requirements
- R1: Enable register 0 (select 0) holds bits for sources 0..3 and register 1 (select 1) holds bits for sources 4..7. Bit b of register r controls source 4*r+b, where source 0 is external 0, 1 is external 1, 2 is timer 1, 3 is timer 2, 4 is timer 3, 5 is timer 4, 6 is the A-D converter and 7 is the serial port. A write stores the 4-bit data in the selected register, and the read data always shows the selected register.
- R2: Both enable registers read 0000 after reset. They also read 0000 after any cycle in which the back-up input is high, even if a write is issued in that cycle.
- R3: A request strobe sets the flag of its source at the next clock edge, and the flag stays set until a poll or an acknowledge clears it.
- R4: The interrupt output is high when the master enable is high and at least one source has both its flag and its enable bit set. The index output then names the lowest such source.
- R5: When the master enable is low, the interrupt output is low and the flags are unchanged. Raising the master enable again presents the same source.
- R6: An acknowledge while the interrupt output is high clears only the flag of the presented source.
- R7: A poll of a source with enable bit 0 and its flag set reports skip=1 in that cycle and clears the flag at the clock edge.
- R8: A poll of a source with enable bit 0 and its flag clear reports skip=0.
- R9: A poll of a source with enable bit 1 reports skip=0 and leaves its flag unchanged.
- R10: A request strobe in the same cycle as a clear of the same flag, by poll or by acknowledge, leaves the flag set.
- R11: A source with enable bit 0 never drives the interrupt output, however long its flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| backup_i | input | 1 | High on entry to the RAM back-up mode; clears both enable registers |
| reg_sel_i | input | 1 | Selects enable register 0 or 1 |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 4 | Write data |
| reg_rdata_o | output | 4 | Contents of the selected register (combinational) |
| req_i | input | 8 | One strobe per source; bit i is source i |
| mie_i | input | 1 | Master interrupt enable |
| irq_valid_o | output | 1 | Interrupt request |
| irq_idx_o | output | 3 | Index of the presented source |
| irq_ack_i | input | 1 | Acknowledge; clears the presented flag |
| poll_i | input | 1 | Poll-and-skip command |
| poll_idx_i | input | 3 | Source being polled |
| poll_skip_o | output | 1 | Skip decision for the poll in this cycle |

## Verification
Register writes, request strobes, poll clears and acknowledge clears take effect at the next clock edge. The register read data, the interrupt output with its index, and the skip decision are combinational views of the current state and inputs. The bench therefore drives each stimulus shortly after a rising edge. It reads the combinational results 1 ns after driving, before the next edge, so a skip is judged in the cycle of its poll. Every effect of a state change is then judged one edge later, after the following rising edge. Flag state, which has no port of its own, is brought out through a second poll with the source disabled, or through the interrupt index as flags are acknowledged one by one.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned IRQ_SRC_N = 8;
  localparam int unsigned IRQ_REG_W = 4;
endpackage

// File: rtl/irq_enable_regs.sv
`timescale 1ns/1ps
module irq_enable_regs #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned REG_W = 4,
  localparam int unsigned NREG  = NSRC / REG_W,
  localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              backup_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [NSRC-1:0]   en_o
);
  logic [REG_W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bank[g] <= '0;
      else if (backup_i)                         bank[g] <= '0;
      else if (wr_i && sel_i == SEL_W'(g))       bank[g] <= wdata_i;
    end
    assign en_o[g*REG_W +: REG_W] = bank[g];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !backup_i && sel_i == SEL_W'(g)) |=> (bank[g] == $past(wdata_i))); // R1
  end

  assign rdata_o = bank[sel_i];

  AST_BACKUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    backup_i |=> (en_o == '0)); // R2
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flags_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= (flags_o & ~clr_i) | set_i;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & $past(flags_o & ~clr_i)) == $past(flags_o & ~clr_i))); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R10
endmodule

// File: rtl/irq_lowest_pick.sv
`timescale 1ns/1ps
module irq_lowest_pick #(
  parameter int unsigned NSRC  = 8,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/irq_poll_arbiter.sv
`timescale 1ns/1ps
module irq_poll_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned NSRC  = IRQ_SRC_N,
  parameter int unsigned REG_W = IRQ_REG_W,
  localparam int unsigned NREG  = NSRC / REG_W,
  localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             backup_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [NSRC-1:0]  req_i,
  input  logic             mie_i,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o,
  input  logic             irq_ack_i,
  input  logic             poll_i,
  input  logic [IDX_W-1:0] poll_idx_i,
  output logic             poll_skip_o
);
  logic [NSRC-1:0] en, flags, pend, clr_poll, clr_ack;
  logic            any_pend;

  irq_enable_regs #(.NSRC(NSRC), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .backup_i(backup_i), .sel_i(reg_sel_i),
    .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .en_o(en)
  );

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(req_i),
    .clr_i(clr_poll | clr_ack), .flags_o(flags)
  );

  assign pend = flags & en;

  irq_lowest_pick #(.NSRC(NSRC)) u_pick (
    .pend_i(pend), .any_o(any_pend), .idx_o(irq_idx_o)
  );

  assign irq_valid_o = mie_i & any_pend;
  assign poll_skip_o = poll_i & ~en[poll_idx_i] & flags[poll_idx_i];
  assign clr_poll    = poll_skip_o ? (NSRC'(1) << poll_idx_i) : '0;
  assign clr_ack     = (irq_valid_o && irq_ack_i) ? (NSRC'(1) << irq_idx_o) : '0;

  AST_IRQ_SOURCE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (en[irq_idx_o] && flags[irq_idx_o])); // R11
  AST_NO_LOWER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> ((pend & ((NSRC'(1) << irq_idx_o) - NSRC'(1))) == '0)); // R4
  AST_INVALID_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && en[poll_idx_i]) |-> !poll_skip_o); // R9
  AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_skip_o && !req_i[poll_idx_i]) |=> !flags[$past(poll_idx_i)]); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ack_i && !req_i[irq_idx_o]) |=> !flags[$past(irq_idx_o)]); // R6
endmodule

// File: tb/tb_irq_poll_arbiter.sv
`timescale 1ns/1ps
module tb_irq_poll_arbiter;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       backup_i = 0;
  logic [0:0] reg_sel_i = 0;
  logic       reg_wr_i = 0;
  logic [3:0] reg_wdata_i = 0;
  logic [3:0] reg_rdata_o;
  logic [7:0] req_i = 0;
  logic       mie_i = 0;
  logic       irq_valid_o;
  logic [2:0] irq_idx_o;
  logic       irq_ack_i = 0;
  logic       poll_i = 0;
  logic [2:0] poll_idx_i = 0;
  logic       poll_skip_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  irq_poll_arbiter dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr_reg(input int s, input logic [3:0] v);
    reg_sel_i = 1'(s); reg_wdata_i = v; reg_wr_i = 1; step(); reg_wr_i = 0;
  endtask

  task automatic set_en(input logic [7:0] m);
    wr_reg(0, m[3:0]); wr_reg(1, m[7:4]);
  endtask

  task automatic pulse_req(input logic [7:0] m);
    req_i = m; step(); req_i = 0;
  endtask

  task automatic do_poll(input int idx, output logic s);
    poll_i = 1; poll_idx_i = 3'(idx); #1 s = poll_skip_o; step(); poll_i = 0;
  endtask

  function automatic int low(input logic [7:0] x);
    for (int i = 7; i >= 0; i--) if (x[i]) low = i;
    if (x == 0) low = 0;
  endfunction

  task automatic clear_all();
    logic s;
    set_en(8'h00);
    for (int i = 0; i < 8; i++) do_poll(i, s);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] p, rem;
    repeat (3) step();
    rst_n = 1; step();

    // R2 reset state
    for (int r = 0; r < 2; r++) begin
      reg_sel_i = 1'(r); #1 chk("R2 reset", reg_rdata_o, 0);
    end
    chk("R4 idle", irq_valid_o, 0);

    // R1 register sweep
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 16; v++) begin
        wr_reg(r, 4'(v)); reg_sel_i = 1'(r); #1 chk("R1 readback", reg_rdata_o, v);
      end
    wr_reg(0, 4'h9); wr_reg(1, 4'h6);
    reg_sel_i = 0; #1 chk("R1 other reg kept", reg_rdata_o, 9);

    // R2 back-up clear, also over a write
    set_en(8'hFF);
    backup_i = 1; reg_wr_i = 1; reg_sel_i = 0; reg_wdata_i = 4'hA; step();
    backup_i = 0; reg_wr_i = 0;
    for (int r = 0; r < 2; r++) begin
      reg_sel_i = 1'(r); #1 chk("R2 backup", reg_rdata_o, 0);
    end

    // R1/R3/R7/R8/R9 poll sweep
    mie_i = 0;
    for (int src = 0; src < 8; src++)
      for (int e = 0; e < 2; e++)
        for (int f = 0; f < 2; f++) begin
          set_en(e ? 8'(1 << src) : 8'h00);
          if (f) pulse_req(8'(1 << src));
          do_poll(src, s);
          chk(e ? "R9 invalid poll skip" : (f ? "R7 poll set" : "R8 poll clear"),
              s, (!e && f) ? 1 : 0);
          set_en(8'h00);
          do_poll(src, s);
          chk(e ? "R9 flag kept" : "R7 flag cleared / R3", s, (e && f) ? 1 : 0);
        end

    // R4/R11 mask sweep
    mie_i = 1;
    for (int m = 0; m < 256; m++) begin
      p = 8'((m * 37 + 11) % 256);
      set_en(8'(m));
      pulse_req(p);
      #1;
      chk("R11 valid vs mask", irq_valid_o, (|(p & 8'(m))) ? 1 : 0);
      if (|(p & 8'(m))) chk("R4 lowest index", irq_idx_o, low(p & 8'(m)));
      clear_all();
    end

    // R6 acknowledge drain order
    set_en(8'hFF);
    for (int q = 1; q < 256; q++) begin
      pulse_req(8'(q));
      rem = 8'(q);
      while (rem != 0) begin
        #1;
        chk("R6 valid", irq_valid_o, 1);
        chk("R6 order", irq_idx_o, low(rem));
        irq_ack_i = 1; step(); irq_ack_i = 0;
        rem[low(rem)] = 1'b0;
      end
      #1 chk("R6 drained", irq_valid_o, 0);
    end

    // R5 master enable
    pulse_req(8'h30);
    mie_i = 0; #1 chk("R5 gated", irq_valid_o, 0);
    repeat (4) step();
    mie_i = 1; #1 chk("R5 flags kept", irq_valid_o, 1);
    chk("R5 same source", irq_idx_o, 4);
    irq_ack_i = 1; step(); step(); irq_ack_i = 0;
    #1 chk("R5 drained", irq_valid_o, 0);

    // R10 request during poll clear
    set_en(8'h00);
    pulse_req(8'h08);
    req_i = 8'h08; do_poll(3, s); req_i = 0;
    chk("R10 poll skip", s, 1);
    do_poll(3, s); chk("R10 flag survives poll", s, 1);

    // R10 request during acknowledge
    set_en(8'hFF);
    pulse_req(8'h02);
    req_i = 8'h02; irq_ack_i = 1; step(); req_i = 0; irq_ack_i = 0;
    #1 chk("R10 flag survives ack", irq_valid_o, 1);
    chk("R10 ack index", irq_idx_o, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule